// File: doc/BRIEF.md
# Serial-Load DAC Register Front-End

This block is the digital input stage of a 12-bit serial-input digital-to-analog converter. It runs on a fast system clock and oversamples three asynchronous pins: a serial clock, a serial data line and an active-low select/load line. While select is low, each rising serial-clock edge shifts one data bit into a 12-bit shift register, most significant bit first. When select returns high, the serial clock is shut off inside the block and the shift register contents are copied into the parallel DAC register. A one-cycle strobe marks that copy.

The shift register's top bit is driven out on a serial output pin. Several devices can then share the serial clock and the select line, with each serial output wired to the next device's data input. During a transfer each device passes its previously held word down the chain, and one rising select edge updates every device at once. The internal shift clock is the serial clock gated by the inverted select level. If select falls while the serial clock is high, one extra shift therefore occurs, and the block reproduces it on purpose.

Top module: `dacfe_top`

## Requirements
- R1: After select goes low and exactly 12 rising serial-clock edges, a load places the word in the DAC register with the first bit received at bit 11 and the last at bit 0.
- R2: While select is high, serial-clock edges have no effect: the serial output and the DAC code stay unchanged, and a later load with no shifts in between reproduces the previously loaded word.
- R3: A low-to-high transition of select copies the shift register into the DAC register, and the update strobe is high for exactly one system cycle, in the cycle in which the new code first appears.
- R4: The DAC code changes only in a strobe cycle, and it keeps its old value while bits are being shifted.
- R5: The serial output equals bit 11 of the shift register, so during a transfer it emits the previously held word, bit 11 first.
- R6: Reset clears the DAC code to 0, the serial output to 0 and the strobe to 0.
- R7: If select falls while the serial clock is high, one shift occurs at that moment and captures the data line's value then.
- R8: If the serial clock rises in the same sample in which select rises, no shift occurs and the load takes the contents from before that edge.
- R9: The serial output shows the shifted value 3 system cycles after a rising serial-clock pin edge, and the strobe and new code appear 3 system cycles after a rising select pin edge.
- R10: When more than 12 bits are clocked in one transfer, the load keeps the last 12 bits received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| sdi_i | input | 1 | Serial data pin, asynchronous |
| csn_i | input | 1 | Active-low select/load pin, asynchronous |
| sdo_o | output | 1 | Serial output (shift register bit 11) |
| dac_code_o | output | 12 | Parallel DAC register |
| upd_stb_o | output | 1 | One-cycle strobe when the DAC register is loaded |

## Verification
A shift and a load can fall in the same sampled cycle when the serial clock and the select line rise together. The bench provokes this by driving both pins on the same falling system-clock edge after eleven shifted bits. It expects no shift: the loaded code must be the bit left over from the previous word followed by the eleven new bits. A second edge case, select falling while the serial clock is already high, is judged by the extra leading bit that appears in the loaded code.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    // Pin bit positions inside the synchronizer vector
    localparam int PIN_SCLK  = 0;
    localparam int PIN_SDI   = 1;
    localparam int PIN_CSN   = 2;
    localparam int PIN_COUNT = 3;

    // Idle pin levels: select high, clock and data low
    localparam logic [PIN_COUNT-1:0] PIN_IDLE = 3'b100;

    // Events decoded from synchronized pins, valid for one system cycle
    typedef struct packed {
        logic shift;
        logic load;
    } dacfe_evt_t;

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_i,
    output logic [WIDTH-1:0] pins_s_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.chain[0] = pins_i;
        for (int s = 1; s < STAGES; s++) begin
            state_d.chain[s] = state_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                state_q.chain[s] <= RST_VAL;
            end
        end else begin
            state_q <= state_d;
        end
    end

    assign pins_s_o = state_q.chain[STAGES-1];

endmodule

// File: rtl/dacfe_edge.sv
module dacfe_edge
    import dacfe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_s_i,
    input  logic       csn_s_i,
    output dacfe_evt_t evt_o
);

    typedef struct packed {
        logic gclk_prev;
        logic csn_prev;
    } edge_state_t;

    edge_state_t state_d, state_q;
    logic        gclk;

    // Gated shift clock: serial clock only counts while select is low
    assign gclk = sclk_s_i & ~csn_s_i;

    always_comb begin
        state_d           = state_q;
        state_d.gclk_prev = gclk;
        state_d.csn_prev  = csn_s_i;
        evt_o.shift       = gclk & ~state_q.gclk_prev;
        evt_o.load        = csn_s_i & ~state_q.csn_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.gclk_prev <= 1'b0;
            state_q.csn_prev  <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/dacfe_shift.sv
module dacfe_shift #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              sdi_s_i,
    output logic [CODE_W-1:0] word_o,
    output logic              sdo_o
);

    typedef struct packed {
        logic [CODE_W-1:0] sr;
    } shift_state_t;

    shift_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (shift_i) begin
            state_d.sr = {state_q.sr[CODE_W-2:0], sdi_s_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.sr <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign word_o = state_q.sr;
    assign sdo_o  = state_q.sr[CODE_W-1];

endmodule

// File: rtl/dacfe_hold.sv
module dacfe_hold #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] word_i,
    output logic [CODE_W-1:0] code_o,
    output logic              stb_o
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              stb;
    } hold_state_t;

    hold_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.stb = load_i;
        if (load_i) begin
            state_d.code = word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.code <= '0;
            state_q.stb  <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign code_o = state_q.code;
    assign stb_o  = state_q.stb;

endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
    import dacfe_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              csn_i,
    output logic              sdo_o,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              upd_stb_o
);

    logic [PIN_COUNT-1:0] pins_raw;
    logic [PIN_COUNT-1:0] pins_s;
    logic                 sclk_s;
    logic                 sdi_s;
    logic                 csn_s;
    dacfe_evt_t           evt;
    logic                 shift_pulse;
    logic                 load_pulse;
    logic [CODE_W-1:0]    shift_word;

    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_SCLK] = sclk_i;
        pins_raw[PIN_SDI]  = sdi_i;
        pins_raw[PIN_CSN]  = csn_i;
    end

    dacfe_sync #(
        .WIDTH   (PIN_COUNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_i   (pins_raw),
        .pins_s_o (pins_s)
    );

    assign sclk_s = pins_s[PIN_SCLK];
    assign sdi_s  = pins_s[PIN_SDI];
    assign csn_s  = pins_s[PIN_CSN];

    dacfe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s_i (sclk_s),
        .csn_s_i  (csn_s),
        .evt_o    (evt)
    );

    assign shift_pulse = evt.shift;
    assign load_pulse  = evt.load;

    dacfe_shift #(
        .CODE_W (CODE_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift_pulse),
        .sdi_s_i (sdi_s),
        .word_o  (shift_word),
        .sdo_o   (sdo_o)
    );

    dacfe_hold #(
        .CODE_W (CODE_W)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_pulse),
        .word_i (shift_word),
        .code_o (dac_code_o),
        .stb_o  (upd_stb_o)
    );

endmodule

// File: rtl/dacfe_checks.sv
module dacfe_checks #(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csn_s,
    input logic              shift_pulse,
    input logic              sdo_o,
    input logic [CODE_W-1:0] dac_code_o,
    input logic              upd_stb_o
);

    logic [2:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 3'd7) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (dac_code_o == '0 && !sdo_o && !upd_stb_o)); // R6

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb_o |=> !upd_stb_o); // R3

    AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd1 && !upd_stb_o) |-> $stable(dac_code_o)); // R4

    AST_LOAD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd3 && upd_stb_o) |-> ($past(csn_s) && !$past(csn_s, 2))); // R3

    AST_SDO_ONLY_ON_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2 && !$past(shift_pulse)) |-> $stable(sdo_o)); // R5

endmodule

bind dacfe_top dacfe_checks #(.CODE_W(CODE_W)) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .csn_s       (csn_s),
    .shift_pulse (shift_pulse),
    .sdo_o       (sdo_o),
    .dac_code_o  (dac_code_o),
    .upd_stb_o   (upd_stb_o)
);

// File: tb/dacfe_top_test.sv
module dacfe_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        csn = 1'b1;
    logic        sdo;
    logic [11:0] code;
    logic        stb;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [11:0] sr_m = '0;
    logic [11:0] dac_m = '0;

    always #2 clk = ~clk;

    dacfe_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk),
        .sdi_i      (sdi),
        .csn_i      (csn),
        .sdo_o      (sdo),
        .dac_code_o (code),
        .upd_stb_o  (stb)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // One serial bit; optionally check sdo exactly 3 cycles after the rise
    task automatic shift_bit(bit b, bit chk);
        sdi = b;
        tick(4);
        sclk = 1'b1;
        sr_m = {sr_m[10:0], b};
        tick(3);
        if (chk) check(sdo == sr_m[11], "R5/R9", "sdo after rise", sdo, sr_m[11]);
        tick(1);
        sclk = 1'b0;
    endtask

    task automatic send_bits(logic [31:0] v, int n, bit chk);
        for (int i = n - 1; i >= 0; i--) shift_bit(v[i], chk);
    endtask

    task automatic begin_xfer();
        csn = 1'b0;
        tick(4);
    endtask

    // Raise select (optionally with sclk) and judge strobe timing and code
    task automatic end_load(string req, bit with_sclk);
        int cnt = 0;
        int first = 0;
        logic [11:0] old = dac_m;
        csn = 1'b1;
        if (with_sclk) sclk = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            tick(1);
            if (stb) begin
                cnt++;
                if (first == 0) first = i;
            end
            if (i == 2) check(code == old, "R4", "code before load", code, old);
        end
        dac_m = sr_m;
        check(cnt == 1, "R3", "strobe cycles", cnt, 1);
        check(first == 3, "R9", "strobe latency", first, 3);
        check(code == dac_m, req, "loaded code", code, dac_m);
        sclk = 1'b0;
        tick(4);
    endtask

    task automatic t_reset();
        check(code == 12'h000, "R6", "code after reset", code, 0);
        check(sdo == 1'b0, "R6", "sdo after reset", sdo, 0);
        check(stb == 1'b0, "R6", "strobe after reset", stb, 0);
    endtask

    task automatic t_basic();
        begin_xfer();
        send_bits(32'hA5C, 12, 1'b0);
        check(code == 12'h000, "R4", "code during shift", code, 0);
        end_load("R1", 1'b0);
        check(code == 12'hA5C, "R1", "msb-first word", code, 12'hA5C);
    endtask

    task automatic t_chain();
        begin_xfer();
        check(sdo == 1'b1, "R5", "sdo holds old msb", sdo, 1);
        send_bits(32'h3F0, 12, 1'b1);
        check(code == 12'hA5C, "R4", "code during chain shift", code, 12'hA5C);
        end_load("R5", 1'b0);
        check(code == 12'h3F0, "R1", "second word", code, 12'h3F0);
    endtask

    task automatic t_ignored();
        logic sdo0 = sdo;
        for (int i = 0; i < 5; i++) begin
            sdi = i[0];
            tick(3);
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
            tick(1);
            check(sdo == sdo0, "R2", "sdo while select high", sdo, sdo0);
            check(code == 12'h3F0, "R2", "code while select high", code, 12'h3F0);
        end
        begin_xfer();
        end_load("R2", 1'b0);
        check(code == 12'h3F0, "R2", "reload without shifts", code, 12'h3F0);
    endtask

    task automatic t_long();
        begin_xfer();
        send_bits(32'hF1234, 20, 1'b0);
        end_load("R10", 1'b0);
        check(code == 12'h234, "R10", "last 12 bits kept", code, 12'h234);
    endtask

    task automatic t_spurious();
        sdi = 1'b1;
        tick(2);
        sclk = 1'b1;
        tick(4);
        csn = 1'b0;
        sr_m = {sr_m[10:0], 1'b1};
        tick(4);
        sclk = 1'b0;
        tick(2);
        send_bits(32'h0AA, 11, 1'b0);
        end_load("R7", 1'b0);
        check(code == 12'h8AA, "R7", "extra leading shift", code, 12'h8AA);
    endtask

    task automatic t_coincide();
        begin_xfer();
        send_bits(32'h155, 11, 1'b0);
        sdi = 1'b1;
        end_load("R8", 1'b1);
        check(code == 12'h155, "R8", "no shift at load edge", code, 12'h155);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_basic();
        t_chain();
        t_ignored();
        t_long();
        t_spurious();
        t_coincide();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule